// File: doc/BRIEF.md
# Isolated-Zero Glitch Removal Filter

This block cleans a serial bit stream. One bit enters on each rising clock edge. The bits leave on a serial output after a fixed latency. Along the way, any single 0 that sits between two 1s is replaced by a 1. Runs of two or more 0s, and every 1, pass through with their timing unchanged.

The core is a three-stage register: a first stage, a middle stage and a last stage. It normally moves data along like a shift register. When a 1 arrives while the middle stage holds 1, all three stages load 1 together. This closes a one-bit gap before it can reach the last stage. The output is the last stage. A synchronous reset clears all three stages.

Top module: `zgap_filter`

## Requirements
- R1: When `rst` is high at a rising edge, all three stages load 0, whatever `din` is. `dout` reads 0 after that edge.
- R2: At every rising edge without reset, the first stage loads `din`.
- R3: At every rising edge without reset, the middle stage loads (first stage) OR (middle stage AND `din`).
- R4: At every rising edge without reset, the last stage loads the middle stage. `dout` is the last stage, so a bit sampled at edge k first shows on `dout` after edge k+2.
- R5: If `din` is 1 and the middle stage is 1 at a rising edge without reset, the state after that edge is all ones.
- R6: A 1,0,1 input pattern comes out on `dout` as three consecutive 1s. After the pipeline has been cleared by reset, `dout` never shows a lone 0 with 1 on both sides.
- R7: Two consecutive 0s sampled at edges k and k+1 appear as 0 on `dout` after edges k+2 and k+3.
- R8: A single 1 with 0s on both sides, entered from the cleared state, appears on `dout` as exactly one 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| rst  | input  | 1 | Synchronous reset, active high |
| din  | input  | 1 | Serial input bit, sampled every edge |
| dout | output | 1 | Filtered serial output (last stage) |

## Verification
The assertions assume that `rst` and `din` are stable and 0 or 1 around each rising edge. They also assume that the design is reset before any property is relied on, since the gap check on `dout` relates only cycles that follow a reset. The bench changes its inputs 1 ns after each rising edge and holds reset for one or more edges before any filtered stream. Through this, every checked edge sees defined inputs and starts from the cleared state.

// File: rtl/zgap_filter.sv
module zgap_filter (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [2:0] stg;
  logic       bridge;
  logic [2:0] stg_nx;

  assign bridge = din & stg[1];
  assign stg_nx = {stg[1], stg[0] | bridge, din};

  always_ff @(posedge clk) begin
    if (rst) stg <= 3'b000;
    else     stg <= stg_nx;
  end

  assign dout = stg[2];

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) AST_RESET_CLEARS: assert (stg == 3'b000 && dout == 1'b0); // R1
  end

  AST_FIRST_TRACKS_IN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stg[0] == $past(din)); // R2

  AST_LAST_TRACKS_MID: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dout == $past(stg[1])); // R4

  AST_GAP_FILL: assert property (@(posedge clk) disable iff (rst)
    (din && stg[1]) |=> stg == 3'b111); // R5

  AST_NO_LONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(dout) |=> !dout); // R6

  AST_ZERO_PAIR_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!din ##1 !din) |=> ##1 !dout ##1 !dout); // R7

endmodule

// File: tb/sim_zgap_filter.sv
module sim_zgap_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] mdl = 3'b000;
  logic done = 1'b0;

  always #5 clk = ~clk;

  zgap_filter u0 (.clk(clk), .rst(rst), .din(din), .dout(dout));

  localparam int NV = 12;
  localparam logic [1:0] VEC [NV] = '{
    2'b10, 2'b00, 2'b11, 2'b01, 2'b01, 2'b10,
    2'b10, 2'b01, 2'b11, 2'b11, 2'b01, 2'b01
  };

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic r);
    din = d;
    rst = r;
    @(posedge clk);
    if (r) mdl = 3'b000;
    else   mdl = {mdl[1], mdl[0] | (mdl[1] & d), d};
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check(dout, 1'b0, "R1 reset state");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][1], 1'b0);
      check(dout, VEC[i][0], "R6/R7 vector table");
    end

    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check(dout, 1'b0, "R1 reset overrides din=1");
    step(1'b0, 1'b0);
    check(dout, 1'b0, "R1 cleared stage 2");
    step(1'b0, 1'b0);
    check(dout, 1'b0, "R1 cleared stage 3");

    step(1'b1, 1'b0);
    check(dout, 1'b0, "R8 lone one latency edge 1");
    step(1'b0, 1'b0);
    check(dout, 1'b0, "R4 lone one latency edge 2");
    step(1'b0, 1'b0);
    check(dout, 1'b1, "R8 lone one reaches output after k+2");
    step(1'b0, 1'b0);
    check(dout, 1'b0, "R8 lone one is single");
    step(1'b0, 1'b0);
    check(dout, 1'b0, "R8 trailing zero");

    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check(dout, 1'b1, "R2 ones fill pipeline");
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    check(dout, 1'b1, "R5 gap bridged, output stays 1");
    step(1'b0, 1'b0);
    check(dout, 1'b1, "R5 state after gap fill");
    step(1'b0, 1'b0);
    check(dout, 1'b1, "R3 middle held the fill");
    step(1'b0, 1'b0);
    check(dout, 1'b0, "R7 zero pair arrives");

    for (int i = 0; i < 3000; i++) begin
      logic d;
      logic r;
      d = ($urandom % 3) != 0;
      if (i % 5 == 0) d = ($urandom % 2) != 0;
      r = ($urandom % 97) == 0;
      step(d, r);
      check(dout, mdl[2], "R2/R3/R4/R5 random vs model");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule